// File: doc/BRIEF.md
# Operand-Latched ALU with Deferred Carry

This block is the arithmetic unit of a move-based processor, where every instruction is a transfer from a source address to a destination address. Two operand registers sit on the destination side. A move to the first operand address loads operand A, and a move to the second operand address loads operand B. On every clock the unit evaluates all of its operators at once from the held operands and registers each result. Any of those results can then be read on a later cycle by presenting its source code on the read port.

The carry of an addition, the borrow of a subtraction, and the bits pushed out by the two logical shifts are kept in side registers. A side register is loaded only on a cycle in which the matching result is actually read. After that it keeps its value while other moves run, until a later carry, rotate-left or rotate-right read picks it up. A program can therefore read a sum, store it, and fetch its carry several instructions later.

Top module: `alu_deferred_carry`

## Requirements
- R1: While reset is asserted, every operand, result and side register is zero, so every source code reads 0.
- R2: Operand A loads `wr_data` only when `wr_en` is high and `wr_dst` equals `DST_A`. Operand B loads only when `wr_en` is high and `wr_dst` equals `DST_B`. Any other write leaves both operands unchanged.
- R3: A value read from `rd_data` is computed from the operands held one clock earlier. An operand written at edge k is reflected in reads taken after edge k+1.
- R4: Source 0 returns (A+B) mod 256. Source 1 returns (A−B) mod 256.
- R5: Source 2 returns A AND B, source 3 returns A OR B, and source 4 returns A XOR B.
- R6: Source 5 returns A shifted left by B[2:0], and source 6 returns A shifted right by B[2:0]. Vacated bits are filled with zeros.
- R7: Source 9 returns the low 8 bits of A×B, source 10 returns the quotient A/B, and source 11 returns the remainder A mod B.
- R8: When B is 0, source 10 returns 8'hFF and source 11 returns A.
- R9: The carry register loads only on a cycle in which `rd_en` is high and the source is 0 or 1. It takes the carry out of A+B for source 0, and for source 1 it takes 1 if A<B. Source 12 returns the carry in bit 0, with the other bits zero.
- R10: Source 7 returns the bits shifted out by the most recent read of source 5, placed in their low-order positions. Source 8 returns the bits shifted out by the most recent read of source 6, placed in their high-order positions. Both values survive any number of other moves.
- R11: Source codes 13 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | A move writes a destination this cycle |
| wr_dst | input | 4 | Destination address of the move |
| wr_data | input | 8 | Data carried by the move |
| rd_en | input | 1 | A move reads an ALU source this cycle |
| rd_src | input | 4 | Source code of the ALU result being read |
| rd_data | output | 8 | Selected result |

## Verification
The bench concentrates on the deferred side registers. It reads a sum, then runs a string of unrelated writes and reads, and only then fetches the carry or the rotated bits. A design that loaded these registers every cycle, or on any read, would return the carry of the wrong operation. Division and modulus by zero are forced directly: a design that divided blindly would return X or 0 instead of all ones and A. Writes to neighbouring destination addresses, and shifts by 0 and by 7, expose address decoding that is too loose and shift-out bits taken from the wrong end.

// File: rtl/alu_dc_pkg.sv
package alu_dc_pkg;
  localparam int SRC_W = 4;

  typedef enum logic [SRC_W-1:0] {
    SRC_ADD   = 4'd0,
    SRC_SUB   = 4'd1,
    SRC_AND   = 4'd2,
    SRC_OR    = 4'd3,
    SRC_XOR   = 4'd4,
    SRC_SLL   = 4'd5,
    SRC_SRL   = 4'd6,
    SRC_ROL   = 4'd7,
    SRC_ROR   = 4'd8,
    SRC_MUL   = 4'd9,
    SRC_DIV   = 4'd10,
    SRC_MOD   = 4'd11,
    SRC_CARRY = 4'd12
  } src_e;
endpackage

// File: rtl/alu_dc_operands.sv
module alu_dc_operands #(
  parameter int W     = 8,
  parameter int DST_W = 4,
  parameter logic [DST_W-1:0] DST_A = 4'd1,
  parameter logic [DST_W-1:0] DST_B = 4'd2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DST_W-1:0] wr_dst,
  input  logic [W-1:0]     wr_data,
  output logic [W-1:0]     a_q,
  output logic [W-1:0]     b_q
);
  logic load_a, load_b;
  assign load_a = wr_en && (wr_dst == DST_A);
  assign load_b = wr_en && (wr_dst == DST_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (load_a) a_q <= wr_data;
      if (load_b) b_q <= wr_data;
    end
  end

  // R2
  opa_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_dst == DST_A) |=> $stable(a_q));
  // R2
  opb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_dst == DST_B) |=> $stable(b_q));
endmodule

// File: rtl/alu_dc_compute.sv
module alu_dc_compute #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_q,
  input  logic [W-1:0] b_q,
  output logic [W-1:0] add_q,
  output logic         add_c_q,
  output logic [W-1:0] sub_q,
  output logic         sub_b_q,
  output logic [W-1:0] and_q,
  output logic [W-1:0] or_q,
  output logic [W-1:0] xor_q,
  output logic [W-1:0] sll_q,
  output logic [W-1:0] sll_out_q,
  output logic [W-1:0] srl_q,
  output logic [W-1:0] srl_out_q,
  output logic [W-1:0] mul_q,
  output logic [W-1:0] div_q,
  output logic [W-1:0] mod_q
);
  localparam int SH_W = $clog2(W);

  function automatic logic [W:0] f_add(input logic [W-1:0] x, input logic [W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  function automatic logic [W:0] f_sub(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] d;
    d = {1'b0, x} - {1'b0, y};
    return d;  // top bit set when a borrow occurs
  endfunction

  // {shifted-out, result}
  function automatic logic [2*W-1:0] f_shl(input logic [W-1:0] x, input logic [SH_W-1:0] s);
    return {{W{1'b0}}, x} << s;
  endfunction

  // {result, shifted-out}
  function automatic logic [2*W-1:0] f_shr(input logic [W-1:0] x, input logic [SH_W-1:0] s);
    return {x, {W{1'b0}}} >> s;
  endfunction

  function automatic logic [W-1:0] f_div(input logic [W-1:0] x, input logic [W-1:0] y);
    return (y == '0) ? {W{1'b1}} : x / y;
  endfunction

  function automatic logic [W-1:0] f_mod(input logic [W-1:0] x, input logic [W-1:0] y);
    return (y == '0) ? x : x % y;
  endfunction

  logic [W:0]     add_n, sub_n;
  logic [2*W-1:0] shl_n, shr_n, mul_n;

  always_comb begin
    add_n = f_add(a_q, b_q);
    sub_n = f_sub(a_q, b_q);
    shl_n = f_shl(a_q, b_q[SH_W-1:0]);
    shr_n = f_shr(a_q, b_q[SH_W-1:0]);
    mul_n = {{W{1'b0}}, a_q} * {{W{1'b0}}, b_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      add_q <= '0; add_c_q <= 1'b0; sub_q <= '0; sub_b_q <= 1'b0;
      and_q <= '0; or_q <= '0; xor_q <= '0;
      sll_q <= '0; sll_out_q <= '0; srl_q <= '0; srl_out_q <= '0;
      mul_q <= '0; div_q <= '0; mod_q <= '0;
    end else begin
      add_q     <= add_n[W-1:0];
      add_c_q   <= add_n[W];
      sub_q     <= sub_n[W-1:0];
      sub_b_q   <= sub_n[W];
      and_q     <= a_q & b_q;
      or_q      <= a_q | b_q;
      xor_q     <= a_q ^ b_q;
      sll_q     <= shl_n[W-1:0];
      sll_out_q <= shl_n[2*W-1:W];
      srl_q     <= shr_n[2*W-1:W];
      srl_out_q <= shr_n[W-1:0];
      mul_q     <= mul_n[W-1:0];
      div_q     <= f_div(a_q, b_q);
      mod_q     <= f_mod(a_q, b_q);
    end
  end

  // R8
  div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_q == '0) |=> (div_q == {W{1'b1}}));
  // R8
  mod_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_q == '0) |=> (mod_q == $past(a_q)));
  // R9
  borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_q < b_q) |=> sub_b_q);
endmodule

// File: rtl/alu_dc_side.sv
module alu_dc_side #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_add,
  input  logic         cap_sub,
  input  logic         cap_sll,
  input  logic         cap_srl,
  input  logic         add_c,
  input  logic         sub_b,
  input  logic [W-1:0] sll_out,
  input  logic [W-1:0] srl_out,
  output logic         carry_q,
  output logic [W-1:0] rol_q,
  output logic [W-1:0] ror_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
      rol_q   <= '0;
      ror_q   <= '0;
    end else begin
      if (cap_add)      carry_q <= add_c;
      else if (cap_sub) carry_q <= sub_b;
      if (cap_sll) rol_q <= sll_out;
      if (cap_srl) ror_q <= srl_out;
    end
  end

  // R9
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_add || cap_sub) |=> $stable(carry_q));
  // R10
  rol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_sll |=> $stable(rol_q));
  // R10
  ror_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_srl |=> $stable(ror_q));
  // R9
  cap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cap_add, cap_sub, cap_sll, cap_srl}) <= 1);
endmodule

// File: rtl/alu_deferred_carry.sv
module alu_deferred_carry
  import alu_dc_pkg::*;
#(
  parameter int W     = 8,
  parameter int DST_W = 4,
  parameter logic [DST_W-1:0] DST_A = 4'd1,
  parameter logic [DST_W-1:0] DST_B = 4'd2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DST_W-1:0] wr_dst,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_en,
  input  logic [SRC_W-1:0] rd_src,
  output logic [W-1:0]     rd_data
);
  logic [W-1:0] a_q, b_q;
  logic [W-1:0] add_q, sub_q, and_q, or_q, xor_q, sll_q, sll_out_q;
  logic [W-1:0] srl_q, srl_out_q, mul_q, div_q, mod_q, rol_q, ror_q;
  logic         add_c_q, sub_b_q, carry_q;
  logic         cap_add, cap_sub, cap_sll, cap_srl;

  assign cap_add = rd_en && (rd_src == SRC_ADD);
  assign cap_sub = rd_en && (rd_src == SRC_SUB);
  assign cap_sll = rd_en && (rd_src == SRC_SLL);
  assign cap_srl = rd_en && (rd_src == SRC_SRL);

  alu_dc_operands #(.W(W), .DST_W(DST_W), .DST_A(DST_A), .DST_B(DST_B)) u_ops (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dst(wr_dst),
    .wr_data(wr_data), .a_q(a_q), .b_q(b_q));

  alu_dc_compute #(.W(W)) u_calc (
    .clk(clk), .rst_n(rst_n), .a_q(a_q), .b_q(b_q),
    .add_q(add_q), .add_c_q(add_c_q), .sub_q(sub_q), .sub_b_q(sub_b_q),
    .and_q(and_q), .or_q(or_q), .xor_q(xor_q),
    .sll_q(sll_q), .sll_out_q(sll_out_q), .srl_q(srl_q), .srl_out_q(srl_out_q),
    .mul_q(mul_q), .div_q(div_q), .mod_q(mod_q));

  alu_dc_side #(.W(W)) u_side (
    .clk(clk), .rst_n(rst_n),
    .cap_add(cap_add), .cap_sub(cap_sub), .cap_sll(cap_sll), .cap_srl(cap_srl),
    .add_c(add_c_q), .sub_b(sub_b_q), .sll_out(sll_out_q), .srl_out(srl_out_q),
    .carry_q(carry_q), .rol_q(rol_q), .ror_q(ror_q));

  always_comb begin
    case (rd_src)
      SRC_ADD:   rd_data = add_q;
      SRC_SUB:   rd_data = sub_q;
      SRC_AND:   rd_data = and_q;
      SRC_OR:    rd_data = or_q;
      SRC_XOR:   rd_data = xor_q;
      SRC_SLL:   rd_data = sll_q;
      SRC_SRL:   rd_data = srl_q;
      SRC_ROL:   rd_data = rol_q;
      SRC_ROR:   rd_data = ror_q;
      SRC_MUL:   rd_data = mul_q;
      SRC_DIV:   rd_data = div_q;
      SRC_MOD:   rd_data = mod_q;
      SRC_CARRY: rd_data = {{(W-1){1'b0}}, carry_q};
      default:   rd_data = '0;
    endcase
  end

  // R11
  unused_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_src > SRC_CARRY) |-> (rd_data == '0));
  // R9
  carry_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_src == SRC_CARRY) |-> (rd_data[W-1:1] == '0));
  // R1
  reset_out_chk: assert property (@(posedge clk)
    !rst_n |-> (rd_data == '0));
endmodule

// File: tb/alu_deferred_carry_test.sv
module alu_deferred_carry_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_dst = '0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [3:0] rd_src = '0;
  logic [7:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // model state: operands, operands seen by the result registers, side values
  int ma = 0, mb = 0, ra = 0, rb = 0, mcarry = 0, mrol = 0, mror = 0;

  always #2 clk = ~clk;

  alu_deferred_carry uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dst(wr_dst),
    .wr_data(wr_data), .rd_en(rd_en), .rd_src(rd_src), .rd_data(rd_data));

  function automatic int exp_val(input int src);
    int s;
    s = rb % 8;
    case (src)
      0:  return (ra + rb) % 256;
      1:  return (ra - rb + 256) % 256;
      2:  return ra & rb;
      3:  return ra | rb;
      4:  return ra ^ rb;
      5:  return (ra * (2 ** s)) % 256;
      6:  return ra / (2 ** s);
      7:  return mrol;
      8:  return mror;
      9:  return (ra * rb) % 256;
      10: return (rb == 0) ? 255 : ra / rb;
      11: return (rb == 0) ? ra : ra % rb;
      12: return mcarry;
      default: return 0;
    endcase
  endfunction

  function automatic string tag(input int src);
    case (src)
      0, 1: return "R4";
      2, 3, 4: return "R5";
      5, 6: return "R6";
      7, 8: return "R10";
      9: return "R7";
      10, 11: return (rb == 0) ? "R8" : "R7";
      12: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input int exp);
    n_chk++;
    if (int'(rd_data) != exp) begin
      n_fail++;
      $display("FAIL %s src=%0d actual=%0h expected=%0h", req, rd_src, rd_data, exp);
    end
  endtask

  task automatic step(input bit we, input int dst, input int dat, input bit re, input int src);
    int s;
    @(negedge clk);
    wr_en = we; wr_dst = 4'(dst); wr_data = 8'(dat);
    rd_en = re; rd_src = 4'(src);
    #1;
    check(tag(src), exp_val(src));
    @(posedge clk);
    s = rb % 8;
    if (re && src == 0) mcarry = (ra + rb > 255) ? 1 : 0;
    if (re && src == 1) mcarry = (ra < rb) ? 1 : 0;
    if (re && src == 5) mrol = (ra * (2 ** s)) / 256;
    if (re && src == 6) mror = ((ra * 256) / (2 ** s)) % 256;
    ra = ma; rb = mb;
    if (we && dst == 1) ma = dat;
    if (we && dst == 2) mb = dat;
  endtask

  task automatic load(input int a, input int b);
    step(1'b1, 1, a, 1'b0, 15);
    step(1'b1, 2, b, 1'b0, 15);
    step(1'b0, 0, 0, 1'b0, 15);
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    // R1: all sources zero during reset
    for (int s = 0; s < 16; s++) begin
      @(negedge clk);
      rd_src = 4'(s); rd_en = 1'b1; wr_en = 1'b1; wr_dst = 4'd1; wr_data = 8'hAA;
      #1 check("R1", 0);
    end
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    rst_n = 1'b1;

    // R3: latency — operands written, sum visible only after one more edge
    step(1'b1, 1, 8'hF0, 1'b0, 0);
    step(1'b1, 2, 8'h20, 1'b0, 0);  // R3: A was latched, result still old
    step(1'b0, 0, 0, 1'b0, 0);      // R3: ra=F0 rb=0
    step(1'b0, 0, 0, 1'b1, 0);      // R3/R4: F0+20 = 10, carry captured
    // R2: writes to other destinations are ignored
    step(1'b1, 0, 8'h01, 1'b0, 3);
    step(1'b1, 3, 8'h02, 1'b0, 3);
    step(1'b0, 1, 8'h55, 1'b0, 3);  // wr_en low
    step(1'b0, 0, 0, 1'b0, 3);      // R2: OR still F0|20
    // R9: carry survives unrelated traffic
    step(1'b1, 1, 8'h01, 1'b0, 12);
    step(1'b1, 2, 8'h01, 1'b1, 2);
    step(1'b0, 0, 0, 1'b0, 12);     // R9: carry still 1
    // R9: sub borrow
    load(3, 9);
    step(1'b0, 0, 0, 1'b1, 1);
    step(1'b0, 0, 0, 1'b0, 12);     // R9 borrow = 1
    load(9, 3);
    step(1'b0, 0, 0, 1'b0, 1);      // not read-enabled: no capture
    step(1'b0, 0, 0, 1'b0, 12);     // R9 still 1
    // R8: divide by zero
    load(8'h37, 0);
    step(1'b0, 0, 0, 1'b0, 10);
    step(1'b0, 0, 0, 1'b0, 11);
    // R6/R10: shift by 0 and 7, rotate pickup later
    load(8'hB5, 7);
    step(1'b0, 0, 0, 1'b1, 5);
    step(1'b0, 0, 0, 1'b1, 6);
    load(8'h11, 0);
    step(1'b0, 0, 0, 1'b1, 5);      // shift by 0: rol becomes 0
    step(1'b0, 0, 0, 1'b0, 7);      // R10
    step(1'b0, 0, 0, 1'b0, 8);      // R10: ror from shift by 7
    // R7 directed
    load(255, 255);
    step(1'b0, 0, 0, 1'b0, 9);
    step(1'b0, 0, 0, 1'b0, 10);
    step(1'b0, 0, 0, 1'b0, 11);
    // R11 unused codes
    step(1'b0, 0, 0, 1'b1, 13);
    step(1'b0, 0, 0, 1'b1, 14);
    step(1'b0, 0, 0, 1'b1, 15);

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      int d, v, src;
      bit we, re;
      we  = ($urandom % 4) != 0;
      d   = ($urandom % 3 == 0) ? int'($urandom % 16) : int'(1 + $urandom % 2);
      v   = ($urandom % 8 == 0) ? 0 : int'($urandom % 256);
      re  = ($urandom % 2) == 1;
      src = ($urandom % 10 == 0) ? int'($urandom % 16) : int'($urandom % 13);
      step(we, d, v, re, src);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule